// File: doc/BRIEF.md
# Core Memory Cycle Emulator

This block stands in for a magnetic core store that sits behind a processor's storage address and storage buffer registers. An on-chip word array holds the data. Every request, fetch or store alike, runs one complete memory cycle. The read half wipes the addressed word to zero and moves its ones into the buffer register. An edit window follows, in which the processor may overwrite the buffer. The write half then rebuilds the word from the buffer. Each bit is driven to one unless the buffer bit is zero, which inhibits it.

A fetch is a cycle with no buffer load: the word is restored from the buffer and its value appears on the buffer output. A store is a cycle in which the buffer is loaded during the edit window. There is no direct write path into the array. The buffer load port is a valid/ready stream. Ready is high only during the edit window. A beat is taken on any clock edge where both valid and ready are high. A producer that holds valid while ready is low gets no effect: its data is not taken and it is not queued, so back-pressure outside the window means the beat is discarded. Start and done are plain control pins.

Top module: `core_cycle_emu`

## Requirements
- R1: After a start is accepted in idle, the block runs a clear step, a sense step, the edit window and a write step. Done then goes high for exactly one clock, in the cycle after the write step. Each accepted start gives exactly one done pulse.
- R2: The buffer is zeroed at the start of the read half, before the sensed ones are ORed into it. When load_ready first rises, buf_out therefore equals exactly the stored word, with no bits left over from an earlier cycle.
- R3: A cycle with no buffer load writes the word back unchanged. A second fetch of the same location returns the same value.
- R4: A beat taken during the edit window replaces the whole buffer. After that cycle the location holds the loaded value, and buf_out shows it while done is high.
- R5: load_ready is high for exactly WINDOW_CYCLES consecutive clocks per cycle (default 4). A beat in any of those clocks, including the last, is taken. load_valid while load_ready is low leaves buf_out unchanged.
- R6: The address is captured when start is accepted and held through both halves. Changing the address input during a cycle has no effect, and other locations are never disturbed.
- R7: A start raised while a cycle is in progress is ignored. It does not begin another cycle or produce an extra done pulse.
- R8: While reset is active and right after it, done is 0, load_ready is 0 and buf_out is 0.
- R9: All 2^ADDR_W words (8192 with the 13-bit default) are addressable. Address 0 and address 8191 are separate locations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a memory cycle; honoured only when idle |
| addr | input | ADDR_W (13) | Word address, captured on an accepted start |
| load_valid | input | 1 | Buffer load beat offered |
| load_data | input | WORD_W (16) | Value to place in the buffer register |
| load_ready | output | 1 | High during the edit window only |
| buf_out | output | WORD_W (16) | Current buffer register contents |
| done | output | 1 | One-clock pulse after the write half |

## Verification
The checker assumes that start and load_valid are synchronous to clk and free of X once reset is released. It also assumes that no one touches the array except through memory cycles. The bench drives every input just after a falling edge. It raises load_valid inside the window only to make real stores. It raises load_valid outside the window, and start during a busy cycle, only on purpose, to show that the block ignores them. It never reads a location that has not been written first, so uninitialised array contents never reach a check.

// File: rtl/core_emu_pkg.sv
package core_emu_pkg;

  // Phases of one memory cycle, in the order they are visited
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CLEAR,
    PH_SENSE,
    PH_WINDOW,
    PH_WRITE,
    PH_DONE
  } phase_t;

endpackage

// File: rtl/core_word_array.sv
module core_word_array #(
  parameter int ADDR_W = 13,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              clr_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] inhibit_n,
  output logic [WORD_W-1:0] sense
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] cells [DEPTH];
  logic [WORD_W-1:0] drive;

  // Each bit line is driven to one unless its inhibit is active (buffer bit zero)
  for (genvar b = 0; b < WORD_W; b++) begin : g_bitline
    assign drive[b] = inhibit_n[b] ? 1'b1 : 1'b0;
  end

  always_ff @(posedge clk) begin
    if (clr_en) begin
      sense       <= cells[addr];
      cells[addr] <= '0;
    end else if (wr_en) begin
      cells[addr] <= cells[addr] | drive;
    end
  end

endmodule

// File: rtl/core_cycle_seq.sv
module core_cycle_seq
  import core_emu_pkg::*;
#(
  parameter int WINDOW_CYCLES = 4
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  output phase_t phase,
  output logic   accept,
  output logic   clr_en,
  output logic   sense_cap,
  output logic   window_open,
  output logic   wr_en,
  output logic   done
);

  localparam int CNT_W = (WINDOW_CYCLES > 1) ? $clog2(WINDOW_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WINDOW_CYCLES - 1);

  phase_t            nxt;
  logic [CNT_W-1:0]  cnt;

  always_comb begin
    nxt = phase;
    case (phase)
      PH_IDLE:   if (start) nxt = PH_CLEAR;
      PH_CLEAR:  nxt = PH_SENSE;
      PH_SENSE:  nxt = PH_WINDOW;
      PH_WINDOW: if (cnt == LAST) nxt = PH_WRITE;
      PH_WRITE:  nxt = PH_DONE;
      PH_DONE:   nxt = PH_IDLE;
      default:   nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      phase <= nxt;
      cnt   <= (phase == PH_WINDOW) ? cnt + 1'b1 : '0;
    end
  end

  assign accept      = (phase == PH_IDLE) && start;
  assign clr_en      = (phase == PH_CLEAR);
  assign sense_cap   = (phase == PH_SENSE);
  assign window_open = (phase == PH_WINDOW);
  assign wr_en       = (phase == PH_WRITE);
  assign done        = (phase == PH_DONE);

endmodule

// File: rtl/core_buffer_reg.sv
module core_buffer_reg #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              capture,
  input  logic [WORD_W-1:0] sense,
  input  logic              load_fire,
  input  logic [WORD_W-1:0] load_data,
  output logic [WORD_W-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rst_n)         q <= '0;
    else if (clear)     q <= '0;
    else if (capture)   q <= q | sense;
    else if (load_fire) q <= load_data;
  end

endmodule

// File: rtl/core_cycle_emu.sv
module core_cycle_emu
  import core_emu_pkg::*;
#(
  parameter int ADDR_W        = 13,
  parameter int WORD_W        = 16,
  parameter int WINDOW_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr,
  input  logic              load_valid,
  input  logic [WORD_W-1:0] load_data,
  output logic              load_ready,
  output logic [WORD_W-1:0] buf_out,
  output logic              done
);

  phase_t            phase;
  logic              accept, clr_en, sense_cap, window_open, wr_en;
  logic [ADDR_W-1:0] lat_addr;
  logic [WORD_W-1:0] sense;

  core_cycle_seq #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .phase       (phase),
    .accept      (accept),
    .clr_en      (clr_en),
    .sense_cap   (sense_cap),
    .window_open (window_open),
    .wr_en       (wr_en),
    .done        (done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      lat_addr <= '0;
    else if (accept) lat_addr <= addr;
  end

  assign load_ready = window_open;

  core_buffer_reg #(.WORD_W(WORD_W)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clr_en),
    .capture   (sense_cap),
    .sense     (sense),
    .load_fire (load_valid && window_open),
    .load_data (load_data),
    .q         (buf_out)
  );

  core_word_array #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_array (
    .clk       (clk),
    .clr_en    (clr_en),
    .wr_en     (wr_en),
    .addr      (lat_addr),
    .inhibit_n (buf_out),
    .sense     (sense)
  );

endmodule

// File: rtl/core_cycle_emu_chk.sv
module core_cycle_emu_chk
  import core_emu_pkg::*;
#(
  parameter int ADDR_W        = 13,
  parameter int WORD_W        = 16,
  parameter int WINDOW_CYCLES = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load_valid,
  input logic              load_ready,
  input logic              done,
  input logic [WORD_W-1:0] buf_out,
  input logic [ADDR_W-1:0] lat_addr,
  input phase_t            phase
);

  logic [15:0] ready_run;

  always_ff @(posedge clk) begin
    if (!rst_n)          ready_run <= '0;
    else if (load_ready) ready_run <= ready_run + 16'd1;
    else                 ready_run <= '0;
  end

  assert_done_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(phase) == PH_WRITE);

  assert_buf_cleared_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SENSE) |-> (buf_out == '0));

  assert_window_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(load_ready) |-> (ready_run == 16'(WINDOW_CYCLES)));

  assert_ignored_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_valid && (phase == PH_IDLE || phase == PH_WRITE || phase == PH_DONE))
      |=> $stable(buf_out));

  assert_addr_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE && $past(phase) != PH_IDLE) |-> $stable(lat_addr));

  assert_busy_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE) |=> (phase != PH_CLEAR));

endmodule

bind core_cycle_emu core_cycle_emu_chk #(
  .ADDR_W        (ADDR_W),
  .WORD_W        (WORD_W),
  .WINDOW_CYCLES (WINDOW_CYCLES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .load_valid (load_valid),
  .load_ready (load_ready),
  .done       (done),
  .buf_out    (buf_out),
  .lat_addr   (lat_addr),
  .phase      (phase)
);

// File: tb/test_core_cycle_emu.sv
module test_core_cycle_emu;

  localparam int AW  = 13;
  localparam int WW  = 16;
  localparam int WIN = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          load_valid = 1'b0;
  logic [WW-1:0] load_data = '0;
  logic          load_ready;
  logic [WW-1:0] buf_out;
  logic          done;

  always #2 clk = ~clk;

  core_cycle_emu #(.ADDR_W(AW), .WORD_W(WW), .WINDOW_CYCLES(WIN)) i_core_cycle_emu (
    .clk(clk), .rst_n(rst_n), .start(start), .addr(addr),
    .load_valid(load_valid), .load_data(load_data), .load_ready(load_ready),
    .buf_out(buf_out), .done(done)
  );

  typedef struct { logic [WW-1:0] v; string tag; } exp_t;

  int            n_cmp = 0;
  int            n_bad = 0;
  int            done_seen = 0;
  int            ready_seen = 0;
  bit            finished = 0;
  logic [WW-1:0] model [int];
  exp_t          sb [$];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on every done pulse
  always @(negedge clk) begin
    if (rst_n && load_ready) ready_seen++;
    if (rst_n && done) begin
      exp_t e;
      done_seen++;
      if (sb.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R7 unexpected done actual=%h expected=none", buf_out);
      end else begin
        e = sb.pop_front();
        check(e.tag, 32'(buf_out), 32'(e.v));
      end
    end
  end

  // Driver: one full memory cycle; lat = window clock of the load (0..WIN-1)
  task automatic run_cycle(input logic [AW-1:0] a, input bit do_load, input logic [WW-1:0] d,
                           input int lat, input bit poke_start, input string tag);
    exp_t e;
    int   base_done, base_ready;
    logic [WW-1:0] old;
    bit   known;
    known = model.exists(int'(a));
    old   = known ? model[int'(a)] : '0;
    base_done  = done_seen;
    base_ready = ready_seen;
    e.v   = do_load ? d : old;
    e.tag = {tag, " done value"};
    sb.push_back(e);
    @(negedge clk); addr = a; start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!load_ready) @(negedge clk);
    if (known) check({tag, " R2 window read"}, 32'(buf_out), 32'(old));
    addr = a ^ 13'h0400;   // R6: scramble the address input mid-cycle
    repeat (lat) @(negedge clk);
    if (poke_start) start = 1'b1;   // R7
    if (do_load) begin load_valid = 1'b1; load_data = d; end
    @(negedge clk); start = 1'b0; load_valid = 1'b0;
    while (done_seen == base_done) @(negedge clk);
    repeat (4) @(negedge clk);
    check({tag, " R1 R7 done count"}, 32'(done_seen - base_done), 32'd1);
    check({tag, " R5 ready length"}, 32'(ready_seen - base_ready), 32'(WIN));
    model[int'(a)] = e.v;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [WW-1:0] hold;
    repeat (3) @(negedge clk);
    check("R8 reset done", 32'(done), 32'd0);
    check("R8 reset ready", 32'(load_ready), 32'd0);
    check("R8 reset buf", 32'(buf_out), 32'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R8 post-reset buf", 32'(buf_out), 32'd0);

    run_cycle(13'h02E7, 1, 16'h04A0, 1, 0, "R4 store");
    run_cycle(13'h02E7, 0, 16'h0000, 0, 0, "R3 fetch1");
    run_cycle(13'h02E7, 0, 16'h0000, 0, 0, "R3 fetch2");
    run_cycle(13'h06E7, 1, 16'h0491, 2, 0, "R6 store other");
    run_cycle(13'h02E7, 0, 16'h0000, 0, 0, "R6 fetch first");
    run_cycle(13'h0000, 1, 16'hFFFF, 0, 0, "R9 store low");
    run_cycle(13'h1FFF, 1, 16'h0000, WIN-1, 0, "R5 R9 last-window store");
    run_cycle(13'h0000, 0, 16'h0000, 0, 0, "R9 fetch low");
    run_cycle(13'h1FFF, 0, 16'h0000, 0, 0, "R2 fetch zero after ones");
    run_cycle(13'h02E7, 1, 16'h5A5A, 1, 1, "R7 busy start");
    run_cycle(13'h02E7, 0, 16'h0000, 0, 0, "R7 R4 fetch");

    // R5: load offered while idle is ignored
    hold = buf_out;
    @(negedge clk); load_valid = 1'b1; load_data = ~hold;
    repeat (3) @(negedge clk);
    load_valid = 1'b0;
    check("R5 idle load ignored", 32'(buf_out), 32'(hold));
    run_cycle(13'h02E7, 0, 16'h0000, 0, 0, "R5 word after idle load");

    for (int i = 0; i < 6; i++) begin
      logic [AW-1:0] a;
      logic [WW-1:0] p;
      a = AW'(i * 977 + 5);
      p = WW'(16'h1357 * (i + 1)) ^ 16'h8001;
      run_cycle(a, 1, p, i % WIN, 0, "R4 pattern store");
      run_cycle(a, 0, 16'h0000, 0, 0, "R3 pattern fetch");
    end

    check("R1 scoreboard drained", 32'(sb.size()), 32'd0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule